// File: doc/BRIEF.md
# Multi-Cycle 32-bit RISC Core

This block is a compact 32-bit processor core that spends several clock cycles on each instruction. It has one word-addressed memory that holds both code and data, and one ALU. A state machine steers both through the steps of an instruction: fetch, decode, execute, memory access and register write-back. Holding registers for the instruction word, the loaded memory word, the two source operands and the ALU result carry values from one step to the next. Each instruction uses only the steps it needs, so the number of cycles depends on the instruction.

The instruction set covers word load and store, register-to-register arithmetic, add-immediate, branch on equal and a conditional move. The ALU is shared across the steps. In fetch it increments the program counter. In decode it computes the branch target before the opcode is known to need it. In execute it forms the result or the effective address. Memory contents are written through a load port, normally while reset is held. Debug read ports and a one-cycle completion pulse let a test environment follow the architectural state.

Top module: `mc_core`

## Requirements
- R1: After synchronous reset, `pc_o` is 0 and the core is in fetch. In every fetch cycle, the word at `pc_o` (word index `pc_o[MIDX+1:2]`) is latched as the instruction, and `pc_o` then advances by 4. The instruction word does not change until the next fetch.
- R2: Branch-if-equal (opcode bits 31:26 = 6'h04; register fields rs bits 25:21 and rt bits 20:16; imm bits 15:0) takes 3 cycles. When rs equals rt, the next PC is PC+4 plus the sign-extended imm shifted left by 2. Otherwise the next PC is PC+4. A branch writes no register and no memory word.
- R3: Load word (opcode 6'h23) takes 5 cycles. It writes rt with the memory word at byte address rs + sign-extended imm. It is the only instruction that uses the write-back step.
- R4: Store word (opcode 6'h2B) takes 4 cycles. It writes rt into memory at byte address rs + sign-extended imm.
- R5: Register arithmetic (opcode 6'h00; rd bits 15:11; funct bits 5:0) takes 4 cycles. It writes rd with rs+rt (funct 6'h20), rs-rt (6'h22), rs AND rt (6'h24), rs OR rt (6'h25) or the signed comparison rs<rt as 0 or 1 (6'h2A).
- R6: Add-immediate (opcode 6'h08) takes 4 cycles and writes rt with rs + sign-extended imm.
- R7: Conditional move (opcode 6'h00, funct 6'h0B) takes 4 cycles. It copies rs into rd when rt is nonzero. When rt is zero, rd keeps its value.
- R8: Register 0 reads as zero at all times, and writes to it are discarded.
- R9: `instr_done` is high for exactly one cycle per instruction: the last cycle of that instruction. In the next cycle the core is in fetch.
- R10: An instruction whose opcode is not listed above changes no register and no memory word and completes in 2 cycles.
- R11: A high `load_en` writes `load_data` into memory word `load_idx` at the clock edge. `dbg_reg_val` shows register `dbg_reg_sel`, and `dbg_mem_val` shows memory word `dbg_mem_sel`. Both debug reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Memory preload write enable |
| load_idx | input | MIDX | Preload word index |
| load_data | input | 32 | Preload data word |
| dbg_reg_sel | input | 5 | Debug register select |
| dbg_reg_val | output | 32 | Value of the selected register |
| dbg_mem_sel | input | MIDX | Debug memory word select |
| dbg_mem_val | output | 32 | Value of the selected memory word |
| pc_o | output | 32 | Current program counter |
| instr_done | output | 1 | High in the final cycle of each instruction |

## Verification
The bench decodes each instruction from its own memory image and derives the expected cycle count: 2, 3, 4 or 5. It then checks `instr_done` at every falling edge, expecting it low in every cycle except that last one.

Register, memory and PC writes land on the rising edge that closes an instruction's final cycle. The bench therefore compares them one falling edge later, in the first cycle of the next instruction:
- `pc_o` is compared with the model's next PC, so a taken branch is checked there.
- For a register or memory write, the bench drives the debug selects to the written location and compares the combinational read after a short settling delay.

A final sweep reads all registers back through the debug port once the program is parked in a branch-to-self loop.

// File: rtl/mc_pkg.sv
package mc_pkg;

   localparam int XLEN = 32;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_MEM    = 3'd3,
      ST_WB     = 3'd4
   } state_e;

   typedef enum logic [2:0] {
      ALU_ADD   = 3'd0,
      ALU_SUB   = 3'd1,
      ALU_AND   = 3'd2,
      ALU_OR    = 3'd3,
      ALU_SLT   = 3'd4,
      ALU_PASSA = 3'd5
   } alu_op_e;

   typedef enum logic [1:0] {
      BSRC_FOUR  = 2'd0,
      BSRC_REG   = 2'd1,
      BSRC_IMM   = 2'd2,
      BSRC_BROFF = 2'd3
   } bsrc_e;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_ADDI  = 6'h08;
   localparam logic [5:0] OP_BEQ   = 6'h04;

   localparam logic [5:0] FN_ADD  = 6'h20;
   localparam logic [5:0] FN_SUB  = 6'h22;
   localparam logic [5:0] FN_AND  = 6'h24;
   localparam logic [5:0] FN_OR   = 6'h25;
   localparam logic [5:0] FN_SLT  = 6'h2A;
   localparam logic [5:0] FN_CMOV = 6'h0B;

   typedef struct packed {
      logic    ir_we;
      logic    pc_we;
      logic    pc_cond;
      logic    ab_we;
      logic    res_we;
      logic    mdr_we;
      logic    mem_we;
      logic    rf_we;
      logic    rf_dst_rd;
      logic    rf_from_mdr;
      logic    a_is_pc;
      logic    addr_is_res;
      bsrc_e   bsrc;
      alu_op_e aluop;
      logic    done;
   } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  alu_op_e      op,
   output logic [W-1:0] result,
   output logic         zero
);

   logic [W-1:0] diff;

   assign diff = op_a - op_b;

   always_comb begin
      case (op)
         ALU_ADD:   result = op_a + op_b;
         ALU_SUB:   result = diff;
         ALU_AND:   result = op_a & op_b;
         ALU_OR:    result = op_a | op_b;
         ALU_SLT:   result = {{(W-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
         ALU_PASSA: result = op_a;
         default:   result = op_a + op_b;
      endcase
   end

   assign zero = (result == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int W     = 32,
   parameter int NREGS = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [$clog2(NREGS)-1:0] ra1,
   input  logic [$clog2(NREGS)-1:0] ra2,
   input  logic [$clog2(NREGS)-1:0] ra3,
   output logic [W-1:0]             rd1,
   output logic [W-1:0]             rd2,
   output logic [W-1:0]             rd3,
   input  logic                     we,
   input  logic [$clog2(NREGS)-1:0] wa,
   input  logic [W-1:0]             wd
);

   localparam int AW = $clog2(NREGS);

   logic [W-1:0] regs_w [NREGS];

   for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
      if (gi == 0) begin : g_zero
         assign regs_w[gi] = '0;
      end else begin : g_store
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we && (wa == AW'(gi)))
               q <= wd;
         end
         assign regs_w[gi] = q;
      end
   end

   assign rd1 = regs_w[ra1];
   assign rd2 = regs_w[ra2];
   assign rd3 = regs_w[ra3];

endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
   parameter int W     = 32,
   parameter int WORDS = 256
) (
   input  logic                     clk,
   input  logic                     ld_en,
   input  logic [$clog2(WORDS)-1:0] ld_idx,
   input  logic [W-1:0]             ld_data,
   input  logic                     we,
   input  logic [W-1:0]             addr,
   input  logic [W-1:0]             wdata,
   output logic [W-1:0]             rdata,
   input  logic [$clog2(WORDS)-1:0] dbg_idx,
   output logic [W-1:0]             dbg_data
);

   localparam int IDXW = $clog2(WORDS);

   logic [W-1:0]    words_q [WORDS];
   logic [IDXW-1:0] idx;
   logic            unused_addr_bits;

   assign idx              = addr[IDXW+1:2];
   assign unused_addr_bits = ^{addr[W-1:IDXW+2], addr[1:0]};

   always_ff @(posedge clk) begin
      if (ld_en)
         words_q[ld_idx] <= ld_data;
      else if (we)
         words_q[idx] <= wdata;
   end

   assign rdata    = words_q[idx];
   assign dbg_data = words_q[dbg_idx];

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   input  logic       b_nonzero,
   output state_e     state_o,
   output ctrl_t      ctl
);

   state_e state_q, state_d;
   logic   is_r, is_known, is_cmov;

   function automatic alu_op_e funct_to_op(input logic [5:0] fn);
      case (fn)
         FN_SUB:  return ALU_SUB;
         FN_AND:  return ALU_AND;
         FN_OR:   return ALU_OR;
         FN_SLT:  return ALU_SLT;
         FN_CMOV: return ALU_PASSA;
         default: return ALU_ADD;
      endcase
   endfunction

   assign is_r     = (opcode == OP_RTYPE);
   assign is_cmov  = is_r && (funct == FN_CMOV);
   assign is_known = is_r || (opcode == OP_LW) || (opcode == OP_SW) ||
                     (opcode == OP_ADDI) || (opcode == OP_BEQ);

   always_comb begin
      ctl     = '0;
      state_d = state_q;
      case (state_q)
         ST_FETCH: begin
            ctl.ir_we   = 1'b1;
            ctl.pc_we   = 1'b1;
            ctl.a_is_pc = 1'b1;
            ctl.bsrc    = BSRC_FOUR;
            ctl.aluop   = ALU_ADD;
            state_d     = ST_DECODE;
         end
         ST_DECODE: begin
            ctl.ab_we   = 1'b1;
            ctl.res_we  = 1'b1;
            ctl.a_is_pc = 1'b1;
            ctl.bsrc    = BSRC_BROFF;
            ctl.aluop   = ALU_ADD;
            if (is_known) begin
               state_d = ST_EXEC;
            end else begin
               ctl.done = 1'b1;
               state_d  = ST_FETCH;
            end
         end
         ST_EXEC: begin
            if (opcode == OP_BEQ) begin
               ctl.bsrc    = BSRC_REG;
               ctl.aluop   = ALU_SUB;
               ctl.pc_cond = 1'b1;
               ctl.done    = 1'b1;
               state_d     = ST_FETCH;
            end else begin
               ctl.res_we = 1'b1;
               ctl.bsrc   = is_r ? BSRC_REG : BSRC_IMM;
               ctl.aluop  = is_r ? funct_to_op(funct) : ALU_ADD;
               state_d    = ST_MEM;
            end
         end
         ST_MEM: begin
            ctl.addr_is_res = 1'b1;
            if (opcode == OP_LW) begin
               ctl.mdr_we = 1'b1;
               state_d    = ST_WB;
            end else if (opcode == OP_SW) begin
               ctl.mem_we = 1'b1;
               ctl.done   = 1'b1;
               state_d    = ST_FETCH;
            end else begin
               ctl.rf_we     = !is_cmov || b_nonzero;
               ctl.rf_dst_rd = is_r;
               ctl.done      = 1'b1;
               state_d       = ST_FETCH;
            end
         end
         ST_WB: begin
            ctl.rf_we       = 1'b1;
            ctl.rf_from_mdr = 1'b1;
            ctl.done        = 1'b1;
            state_d         = ST_FETCH;
         end
         default: begin
            state_d = ST_FETCH;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= ST_FETCH;
      else
         state_q <= state_d;
   end

   assign state_o = state_q;

   AST_DONE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
      ctl.done |=> (state_q == ST_FETCH)); // R9

   AST_WB_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WB) |-> (opcode == OP_LW)); // R3

endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int MEM_WORDS = 256,
   parameter int NREGS     = 32,
   localparam int MIDX     = $clog2(MEM_WORDS),
   localparam int RAW      = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load_en,
   input  logic [MIDX-1:0] load_idx,
   input  logic [31:0]     load_data,
   input  logic [4:0]      dbg_reg_sel,
   output logic [31:0]     dbg_reg_val,
   input  logic [MIDX-1:0] dbg_mem_sel,
   output logic [31:0]     dbg_mem_val,
   output logic [31:0]     pc_o,
   output logic            instr_done
);

   localparam int W = XLEN;

   if (W != 32) begin : g_bad_width
      $error("mc_core: data width must be 32");
   end
   if (NREGS != 32 || RAW != 5) begin : g_bad_regs
      $error("mc_core: register count must be 32 for 5-bit register fields");
   end
   if (MEM_WORDS < 16 || (MEM_WORDS & (MEM_WORDS - 1)) != 0) begin : g_bad_mem
      $error("mc_core: MEM_WORDS must be a power of two of at least 16");
   end

   logic [W-1:0] pc_q, ir_q, a_q, b_q, res_q, mdr_q;
   logic [W-1:0] alu_a, alu_b, alu_y, rf_rd1, rf_rd2, mem_rdata, mem_addr, imm_sx;
   logic         alu_zero;
   logic [5:0]   opcode, funct;
   logic [4:0]   f_rs, f_rt, f_rd;
   logic [RAW-1:0] rf_wa;
   logic [W-1:0]   rf_wd;
   state_e       state;
   ctrl_t        ctl;

   assign opcode = ir_q[31:26];
   assign f_rs   = ir_q[25:21];
   assign f_rt   = ir_q[20:16];
   assign f_rd   = ir_q[15:11];
   assign funct  = ir_q[5:0];
   assign imm_sx = {{(W-16){ir_q[15]}}, ir_q[15:0]};

   mc_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .opcode    (opcode),
      .funct     (funct),
      .b_nonzero (b_q != '0),
      .state_o   (state),
      .ctl       (ctl)
   );

   assign alu_a = ctl.a_is_pc ? pc_q : a_q;

   always_comb begin
      case (ctl.bsrc)
         BSRC_FOUR:  alu_b = W'(4);
         BSRC_REG:   alu_b = b_q;
         BSRC_IMM:   alu_b = imm_sx;
         default:    alu_b = {imm_sx[W-3:0], 2'b00};
      endcase
   end

   mc_alu #(.W(W)) u_alu (
      .op_a   (alu_a),
      .op_b   (alu_b),
      .op     (ctl.aluop),
      .result (alu_y),
      .zero   (alu_zero)
   );

   assign rf_wa = ctl.rf_dst_rd ? f_rd : f_rt;
   assign rf_wd = ctl.rf_from_mdr ? mdr_q : res_q;

   mc_regfile #(.W(W), .NREGS(NREGS)) u_rf (
      .clk (clk),
      .rst (rst),
      .ra1 (f_rs),
      .ra2 (f_rt),
      .ra3 (dbg_reg_sel),
      .rd1 (rf_rd1),
      .rd2 (rf_rd2),
      .rd3 (dbg_reg_val),
      .we  (ctl.rf_we),
      .wa  (rf_wa),
      .wd  (rf_wd)
   );

   assign mem_addr = ctl.addr_is_res ? res_q : pc_q;

   mc_mem #(.W(W), .WORDS(MEM_WORDS)) u_mem (
      .clk      (clk),
      .ld_en    (load_en),
      .ld_idx   (load_idx),
      .ld_data  (load_data),
      .we       (ctl.mem_we),
      .addr     (mem_addr),
      .wdata    (b_q),
      .rdata    (mem_rdata),
      .dbg_idx  (dbg_mem_sel),
      .dbg_data (dbg_mem_val)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         ir_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         res_q <= '0;
         mdr_q <= '0;
      end else begin
         if (ctl.pc_we)
            pc_q <= alu_y;
         else if (ctl.pc_cond && alu_zero)
            pc_q <= res_q;
         if (ctl.ir_we)
            ir_q <= mem_rdata;
         if (ctl.ab_we) begin
            a_q <= rf_rd1;
            b_q <= rf_rd2;
         end
         if (ctl.res_we)
            res_q <= alu_y;
         if (ctl.mdr_we)
            mdr_q <= mem_rdata;
      end
   end

   assign pc_o       = pc_q;
   assign instr_done = ctl.done;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |=> (pc_q == $past(pc_q) + 32'd4)); // R1

   AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (state != ST_FETCH) |=> $stable(ir_q)); // R1

   AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && opcode == OP_BEQ) |-> (!ctl.rf_we && !ctl.mem_we)); // R2

   AST_CMOV_GATE: assert property (@(posedge clk) disable iff (rst)
      (ctl.rf_we && opcode == OP_RTYPE && funct == FN_CMOV) |-> (b_q != '0)); // R7

   AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DECODE && f_rs == 5'd0) |=> (a_q == '0)); // R8

   AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DECODE && ctl.done) |=> (state == ST_FETCH && $stable(pc_q))); // R10

endmodule

// File: tb/mc_core_tb.sv
module mc_core_tb;

   localparam int MW   = 256;
   localparam int MIDX = $clog2(MW);

   logic            clk = 1'b0;
   logic            rst;
   logic            load_en;
   logic [MIDX-1:0] load_idx;
   logic [31:0]     load_data;
   logic [4:0]      dbg_reg_sel;
   logic [31:0]     dbg_reg_val;
   logic [MIDX-1:0] dbg_mem_sel;
   logic [31:0]     dbg_mem_val;
   logic [31:0]     pc_o;
   logic            instr_done;

   always #4 clk = ~clk;

   mc_core #(.MEM_WORDS(MW)) u_dut (
      .clk         (clk),
      .rst         (rst),
      .load_en     (load_en),
      .load_idx    (load_idx),
      .load_data   (load_data),
      .dbg_reg_sel (dbg_reg_sel),
      .dbg_reg_val (dbg_reg_val),
      .dbg_mem_sel (dbg_mem_sel),
      .dbg_mem_val (dbg_mem_val),
      .pc_o        (pc_o),
      .instr_done  (instr_done)
   );

   int          n_chk  = 0;
   int          n_fail = 0;
   int          cyc    = 0;
   logic [31:0] m_mem [MW];
   logic [31:0] m_reg [32];
   logic [31:0] m_pc;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wrap_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         wrap_up();
      end
   end

   function automatic logic [31:0] enc_r(input int rd, input int rs, input int rt, input logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic preload(input int idx, input logic [31:0] w);
      @(negedge clk);
      load_en   = 1'b1;
      load_idx  = MIDX'(idx);
      load_data = w;
      m_mem[idx] = w;
   endtask

   // Executes one instruction in lockstep: entered and left at negedge+delta
   // of an instruction's first cycle.
   task automatic step_instr();
      logic [31:0] ins, simm, ea, nxt;
      logic [5:0]  op, fn;
      int          rs, rt, rd, n, dst;
      string       req;
      bit          is_store;
      ins  = m_mem[m_pc[MIDX+1:2]];
      op   = ins[31:26];
      fn   = ins[5:0];
      rs   = int'(ins[25:21]);
      rt   = int'(ins[20:16]);
      rd   = int'(ins[15:11]);
      simm = {{16{ins[15]}}, ins[15:0]};
      ea   = m_reg[rs] + simm;
      nxt  = m_pc + 32'd4;
      dst  = -1;
      is_store = 1'b0;
      case (op)
         6'h23: begin n = 5; req = "R3"; end
         6'h2B: begin n = 4; req = "R4"; end
         6'h00: begin n = 4; req = (fn == 6'h0B) ? "R7" : "R5"; end
         6'h08: begin n = 4; req = "R6"; end
         6'h04: begin n = 3; req = "R2"; end
         default: begin n = 2; req = "R10"; end
      endcase
      for (int c = 1; c <= n; c++) begin
         if (c == 1) chk("R1 pc at fetch", pc_o, m_pc);
         chk({"R9 done timing for ", req}, 32'(instr_done), 32'(c == n));
         @(negedge clk);
         #1;
      end
      case (op)
         6'h23: begin m_reg[rt] = m_mem[ea[MIDX+1:2]]; dst = rt; end
         6'h2B: begin m_mem[ea[MIDX+1:2]] = m_reg[rt]; is_store = 1'b1; end
         6'h08: begin m_reg[rt] = ea; dst = rt; end
         6'h04: begin if (m_reg[rs] == m_reg[rt]) nxt = m_pc + 32'd4 + {simm[29:0], 2'b00}; end
         6'h00: begin
            dst = rd;
            case (fn)
               6'h20: m_reg[rd] = m_reg[rs] + m_reg[rt];
               6'h22: m_reg[rd] = m_reg[rs] - m_reg[rt];
               6'h24: m_reg[rd] = m_reg[rs] & m_reg[rt];
               6'h25: m_reg[rd] = m_reg[rs] | m_reg[rt];
               6'h2A: m_reg[rd] = ($signed(m_reg[rs]) < $signed(m_reg[rt])) ? 32'd1 : 32'd0;
               6'h0B: if (m_reg[rt] != 0) m_reg[rd] = m_reg[rs];
               default: m_reg[rd] = m_reg[rs] + m_reg[rt];
            endcase
         end
         default: ;
      endcase
      m_reg[0] = 32'd0;
      m_pc     = nxt;
      if (dst >= 0) begin
         dbg_reg_sel = 5'(dst);
         #1;
         chk({req, " register result"}, dbg_reg_val, m_reg[dst]);
      end
      if (is_store) begin
         dbg_mem_sel = ea[MIDX+1:2];
         #1;
         chk({req, " stored word"}, dbg_mem_val, m_mem[ea[MIDX+1:2]]);
      end
   endtask

   initial begin
      rst         = 1'b1;
      load_en     = 1'b0;
      load_idx    = '0;
      load_data   = '0;
      dbg_reg_sel = '0;
      dbg_mem_sel = '0;
      for (int i = 0; i < MW; i++) m_mem[i] = 32'd0;
      for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
      m_pc = 32'd0;

      preload(0,  enc_i(6'h08, 1, 0, 16'd5));        // addi r1 = 5
      preload(1,  enc_i(6'h08, 2, 0, 16'hFFFD));     // addi r2 = -3
      preload(2,  enc_r(3, 1, 2, 6'h20));            // add
      preload(3,  enc_r(4, 1, 2, 6'h22));            // sub
      preload(4,  enc_r(5, 1, 2, 6'h24));            // and
      preload(5,  enc_r(6, 1, 2, 6'h25));            // or
      preload(6,  enc_r(7, 2, 1, 6'h2A));            // slt, negative < positive
      preload(7,  enc_i(6'h23, 8, 0, 16'h0080));     // lw r8, word 32
      preload(8,  enc_i(6'h2B, 4, 0, 16'h0088));     // sw r4, word 34
      preload(9,  enc_i(6'h23, 9, 0, 16'h0088));     // lw r9 back
      preload(10, enc_r(10, 1, 3, 6'h0B));           // cmov taken
      preload(11, enc_r(4, 1, 0, 6'h0B));            // cmov suppressed
      preload(12, enc_i(6'h08, 0, 0, 16'd7));        // write to r0
      preload(13, enc_i(6'h04, 2, 1, 16'd5));        // beq not taken
      preload(14, enc_i(6'h04, 3, 3, 16'd1));        // beq taken over 15
      preload(15, enc_i(6'h08, 12, 0, 16'd99));      // skipped
      preload(16, 32'hFC00_0000);                    // unknown opcode
      preload(17, enc_r(12, 8, 0, 6'h20));           // add r12 = r8
      preload(18, enc_i(6'h04, 0, 0, 16'hFFFF));     // branch to self
      preload(32, 32'h1234_5678);
      @(negedge clk);
      load_en = 1'b0;
      #1;
      chk("R1 reset pc", pc_o, 32'd0);
      chk("R9 reset done low", 32'(instr_done), 32'd0);
      dbg_mem_sel = MIDX'(32);
      #1;
      chk("R11 preload readback", dbg_mem_val, 32'h1234_5678);
      dbg_reg_sel = 5'd1;
      #1;
      chk("R11 register reset value", dbg_reg_val, 32'd0);

      @(negedge clk);
      rst = 1'b0;
      #1;
      for (int k = 0; k < 22; k++) step_instr();

      chk("R2 parked at branch-to-self", pc_o, 32'd72);
      chk("R2 skipped instruction left r12 from add", m_reg[12], 32'h1234_5678);
      for (int i = 0; i < 32; i++) begin
         dbg_reg_sel = 5'(i);
         #1;
         chk((i == 0) ? "R8 r0 final" : "R11 register sweep", dbg_reg_val, m_reg[i]);
      end
      dbg_mem_sel = MIDX'(34);
      #1;
      chk("R4 stored word final", dbg_mem_val, 32'd8);
      wrap_up();
   end

endmodule